// File: doc/BRIEF.md
# Taint-Tracking Compare and Reduce Unit

This combinational unit computes a one-bit result and a one-bit taint flag. The result comes from one of ten operations on two unsigned operands. The operations are four ordered compares, two equality compares, and four reductions of the first operand. Every operand bit has its own taint bit. The output flag reports whether the result might depend on tainted data, given the present values of the clean bits.

The flag is not simply the OR of every taint bit. A feasibility test gates it. If the clean bits already fix the outcome, the flag stays low, whatever values the tainted bits take. One example is two clean bits that differ, which settle an equality compare. Another is a clean zero bit in a reduce-AND. Information-flow checkers and fault-propagation monitors can use this flag to keep taint from spreading pessimistically through comparison logic. Both operands are zero-extended to a shared width W.

Top module: `taint_cmp_unit`

## Requirements
- R1: Opcode 0 returns result = (A == B), and opcode 1 returns result = (A != B).
- R2: Opcodes 2, 3, 4 and 5 return the unsigned results A < B, A > B, A <= B and A >= B, in that order.
- R3: Opcode 6 returns the AND of all bits of A. Opcodes 7 and 8 both return the OR of all bits of A. Opcode 9 returns 1 exactly when A is zero.
- R4: With every bit of tagA and tagB at zero, resultTag is 0 for every opcode.
- R5: For opcodes 0 and 1, let g = tagA | tagB. resultTag is 1 exactly when g is nonzero and A equals B at every bit position where g is 0.
- R6: For opcodes 2 and 5, resultTag is 1 exactly when g is nonzero and (A | g) >= (B & ~g), unsigned.
- R7: For opcodes 3 and 4, the operands swap roles. resultTag is 1 exactly when g is nonzero and (B | g) >= (A & ~g), unsigned.
- R8: For opcode 6, resultTag is 1 exactly when tagA is nonzero and every bit of A with a clear tagA bit is 1.
- R9: For opcodes 7, 8 and 9, resultTag is 1 exactly when tagA is nonzero and every bit of A with a clear tagA bit is 0.
- R10: For opcodes 6 to 9, the values of B and tagB change neither result nor resultTag.
- R11: Opcodes 10 to 15 give result = 0 and resultTag = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | W | First unsigned operand |
| tagA | input | W | Per-bit taint of opA |
| opB | input | W | Second unsigned operand |
| tagB | input | W | Per-bit taint of opB |
| opSel | input | 4 | Operation code |
| result | output | 1 | Value of the selected operation |
| resultTag | output | 1 | Result may depend on tainted bits |

## Verification
The bench targets the blocking cases. In these, a tainted input exists but a clean bit already decides the outcome. Examples are a clean differing bit under equality, a clean high bit that makes the ordered test infeasible, and a clean zero or one bit under a reduction. A design that merely ORs the taint bits would raise the flag in these cases. The bench also drives greater-than and less-or-equal with asymmetric operands, where a missing operand swap flips the flag. It drives reductions with noisy B and tagB, where a leak from B shows up in the flag. It drives unused opcodes, where a design that does not default them to zero outputs stale values.

// File: rtl/taint_cmp_pkg.sv
package taint_cmp_pkg;

  typedef enum logic [3:0] {
    OP_EQ   = 4'd0,
    OP_NE   = 4'd1,
    OP_LT   = 4'd2,
    OP_GT   = 4'd3,
    OP_LE   = 4'd4,
    OP_GE   = 4'd5,
    OP_RAND = 4'd6,
    OP_ROR  = 4'd7,
    OP_RBOOL= 4'd8,
    OP_LNOT = 4'd9
  } tcOp_e;

  // Strobes from decode to datapath
  typedef struct packed {
    logic selEq;     // equality class
    logic selOrd;    // ordered class
    logic selRed;    // reduction class
    logic swapOps;   // exchange A and B before ordered core
    logic invOut;    // invert value result of the class
    logic invRedIn;  // invert A before reduction core
  } tcCtl_t;

endpackage

// File: rtl/taint_cmp_ctrl.sv
module taint_cmp_ctrl
  import taint_cmp_pkg::*;
(
  input  logic [3:0] opSel,
  output tcCtl_t     ctl
);

  always_comb begin
    ctl = '0;
    unique case (opSel)
      OP_EQ:    ctl.selEq = 1'b1;
      OP_NE:    begin ctl.selEq = 1'b1; ctl.invOut = 1'b1; end
      OP_LT:    ctl.selOrd = 1'b1;
      OP_GT:    begin ctl.selOrd = 1'b1; ctl.swapOps = 1'b1; end
      OP_LE:    begin ctl.selOrd = 1'b1; ctl.swapOps = 1'b1; ctl.invOut = 1'b1; end
      OP_GE:    begin ctl.selOrd = 1'b1; ctl.invOut = 1'b1; end
      OP_RAND:  ctl.selRed = 1'b1;
      OP_ROR,
      OP_RBOOL: begin ctl.selRed = 1'b1; ctl.invRedIn = 1'b1; ctl.invOut = 1'b1; end
      OP_LNOT:  begin ctl.selRed = 1'b1; ctl.invRedIn = 1'b1; end
      default:  ctl = '0;
    endcase
  end

endmodule

// File: rtl/taint_cmp_datapath.sv
module taint_cmp_datapath
  import taint_cmp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] tagA,
  input  logic [W-1:0] opB,
  input  logic [W-1:0] tagB,
  input  tcCtl_t       ctl,
  output logic         result,
  output logic         resultTag
);

  logic [W-1:0] grpMask;
  logic         anyTagAB;
  logic         anyTagA;

  logic         eqVal;
  logic         eqProp;

  logic [W-1:0] ordX;
  logic [W-1:0] ordY;
  logic         ltVal;
  logic         ordProp;

  logic [W-1:0] redIn;
  logic         redVal;
  logic         redProp;

  assign grpMask  = tagA | tagB;
  assign anyTagAB = |grpMask;
  assign anyTagA  = |tagA;

  // Equality core: tainted positions forced to one on both sides
  assign eqVal  = (opA == opB);
  assign eqProp = ((opA | grpMask) == (opB | grpMask));

  // Ordered core computes X < Y; largest X vs smallest Y decides feasibility
  assign ordX    = ctl.swapOps ? opB : opA;
  assign ordY    = ctl.swapOps ? opA : opB;
  assign ltVal   = (ordX < ordY);
  assign ordProp = ((ordX | grpMask) >= (ordY & ~grpMask));

  // Reduction core: AND of optionally inverted A
  assign redIn   = ctl.invRedIn ? ~opA : opA;
  assign redVal  = &redIn;
  assign redProp = &(redIn | tagA);

  always_comb begin
    result    = 1'b0;
    resultTag = 1'b0;
    if (ctl.selEq) begin
      result    = eqVal ^ ctl.invOut;
      resultTag = eqProp & anyTagAB;
    end else if (ctl.selOrd) begin
      result    = ltVal ^ ctl.invOut;
      resultTag = ordProp & anyTagAB;
    end else if (ctl.selRed) begin
      result    = redVal ^ ctl.invOut;
      resultTag = redProp & anyTagA;
    end
  end

endmodule

// File: rtl/taint_cmp_unit.sv
module taint_cmp_unit
  import taint_cmp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] tagA,
  input  logic [W-1:0] opB,
  input  logic [W-1:0] tagB,
  input  logic [3:0]   opSel,
  output logic         result,
  output logic         resultTag
);

  tcCtl_t ctl;

  taint_cmp_ctrl u_ctrl (
    .opSel (opSel),
    .ctl   (ctl)
  );

  taint_cmp_datapath #(.W(W)) u_dp (
    .opA       (opA),
    .tagA      (tagA),
    .opB       (opB),
    .tagB      (tagB),
    .ctl       (ctl),
    .result    (result),
    .resultTag (resultTag)
  );

endmodule

// File: rtl/taint_cmp_checks.sv
module taint_cmp_checks #(
  parameter int W = 8
) (
  input logic [W-1:0] opA,
  input logic [W-1:0] tagA,
  input logic [W-1:0] opB,
  input logic [W-1:0] tagB,
  input logic [3:0]   opSel,
  input logic         result,
  input logic         resultTag
);

  always_comb begin
    if (tagA == '0 && tagB == '0)
      p_clean_inputs_r4: assert (!resultTag);
    if (opSel == 4'd1)
      p_ne_value_r1: assert (result == (opA != opB));
    if (opSel == 4'd2)
      p_lt_value_r2: assert (result == (opA < opB));
    if ((opSel == 4'd0 || opSel == 4'd1) && ((opA ^ opB) & ~(tagA | tagB)) != '0)
      p_eq_blocked_r5: assert (!resultTag);
    if (opSel >= 4'd6 && opSel <= 4'd9 && resultTag)
      p_red_source_r10: assert (tagA != '0);
    if (opSel >= 4'd10)
      p_unused_quiet_r11: assert (!result && !resultTag);
  end

endmodule

bind taint_cmp_unit taint_cmp_checks #(.W(W)) u_checks (
  .opA       (opA),
  .tagA      (tagA),
  .opB       (opB),
  .tagB      (tagB),
  .opSel     (opSel),
  .result    (result),
  .resultTag (resultTag)
);

// File: tb/test_taint_cmp_unit.sv
module test_taint_cmp_unit;

  localparam int W = 8;

  typedef struct {
    logic       expR;
    logic       expT;
    string      req;
    logic [3:0] op;
  } sbItem_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opA = '0, tagA = '0, opB = '0, tagB = '0;
  logic [3:0]   opSel = '0;
  logic         result, resultTag;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  sbItem_t sbQ[$];

  always #2.5 clk = ~clk;

  taint_cmp_unit #(.W(W)) i_taint_cmp_unit (
    .opA(opA), .tagA(tagA), .opB(opB), .tagB(tagB),
    .opSel(opSel), .result(result), .resultTag(resultTag)
  );

  function automatic void model(input logic [3:0] op, input logic [W-1:0] a, ta, b, tb,
                                output logic r, output logic t);
    logic [W-1:0] g;
    g = ta | tb;
    r = 1'b0; t = 1'b0;
    case (op)
      4'd0, 4'd1: begin
        r = (op == 4'd0) ? (a == b) : (a != b);
        t = (g != '0) && (((a ^ b) & ~g) == '0);
      end
      4'd2, 4'd5: begin
        r = (op == 4'd2) ? (a < b) : (a >= b);
        t = (g != '0) && ((a | g) >= (b & ~g));
      end
      4'd3, 4'd4: begin
        r = (op == 4'd3) ? (a > b) : (a <= b);
        t = (g != '0) && ((b | g) >= (a & ~g));
      end
      4'd6: begin
        r = (a == '1);
        t = (ta != '0) && ((~a & ~ta) == '0);
      end
      4'd7, 4'd8, 4'd9: begin
        r = (op == 4'd9) ? (a == '0) : (a != '0);
        t = (ta != '0) && ((a & ~ta) == '0);
      end
      default: begin r = 1'b0; t = 1'b0; end
    endcase
  endfunction

  task automatic drive(input logic [3:0] op, input logic [W-1:0] a, ta, b, tb, input string req);
    sbItem_t it;
    @(posedge clk);
    #1;
    opSel = op; opA = a; tagA = ta; opB = b; tagB = tb;
    model(op, a, ta, b, tb, it.expR, it.expT);
    it.req = req; it.op = op;
    sbQ.push_back(it);
  endtask

  // Monitor: one item per cycle, sampled at the falling edge
  always @(negedge clk) begin
    if (!rst && sbQ.size() > 0) begin
      sbItem_t it;
      it = sbQ.pop_front();
      checks++;
      if (result !== it.expR || resultTag !== it.expT) begin
        errors++;
        $display("FAIL %s op=%0d result/tag actual=%b%b expected=%b%b",
                 it.req, it.op, result, resultTag, it.expR, it.expT);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset state: all-zero inputs under equality
    drive(4'd0, 8'h00, 8'h00, 8'h00, 8'h00, "R1 R4 idle");
    // R1 values
    drive(4'd0, 8'h05, 8'h00, 8'h05, 8'h00, "R1 eq");
    drive(4'd1, 8'h05, 8'h00, 8'h06, 8'h00, "R1 ne");
    // R5 equality taint, open and blocked
    drive(4'd0, 8'h0F, 8'h00, 8'h0E, 8'h01, "R5 open");
    drive(4'd1, 8'h0F, 8'h00, 8'h1E, 8'h01, "R5 blocked");
    // R2 ordered values
    drive(4'd2, 8'h03, 8'h00, 8'h05, 8'h00, "R2 lt");
    drive(4'd4, 8'h05, 8'h00, 8'h05, 8'h00, "R2 le");
    drive(4'd5, 8'h04, 8'h00, 8'h05, 8'h00, "R2 ge");
    // R6 open and blocked
    drive(4'd2, 8'h80, 8'h01, 8'h10, 8'h00, "R6 open");
    drive(4'd2, 8'h00, 8'h01, 8'h80, 8'h00, "R6 blocked");
    // R7 swap, open and blocked
    drive(4'd3, 8'h10, 8'h00, 8'h80, 8'h01, "R7 open");
    drive(4'd3, 8'h80, 8'h00, 8'h00, 8'h01, "R7 blocked");
    drive(4'd4, 8'h80, 8'h00, 8'h00, 8'h01, "R7 le blocked");
    // R3/R8 reduce-AND
    drive(4'd6, 8'hFF, 8'h00, 8'h00, 8'h00, "R3 rand");
    drive(4'd6, 8'hFE, 8'h01, 8'h00, 8'h00, "R8 open");
    drive(4'd6, 8'hFC, 8'h01, 8'h00, 8'h00, "R8 blocked");
    // R3/R9 OR-like reductions
    drive(4'd7, 8'h00, 8'h00, 8'h00, 8'h00, "R3 ror");
    drive(4'd7, 8'h01, 8'h01, 8'h00, 8'h00, "R9 open");
    drive(4'd8, 8'h03, 8'h01, 8'h00, 8'h00, "R9 blocked");
    drive(4'd9, 8'h00, 8'h00, 8'h00, 8'h00, "R3 lnot");
    drive(4'd9, 8'h02, 8'h02, 8'h00, 8'h00, "R9 lnot open");
    // R10: B side noise ignored by reductions
    drive(4'd6, 8'hFF, 8'h00, 8'h55, 8'hFF, "R10 rand");
    drive(4'd7, 8'h03, 8'h01, 8'hAA, 8'hFF, "R10 ror");
    // R11 unused codes
    for (int k = 10; k < 16; k++)
      drive(4'(k), 8'hFF, 8'hFF, 8'hFF, 8'hFF, "R11 unused");
    // Sweep: pseudo-random patterns with sparse taint over all opcodes
    begin
      logic [31:0] s;
      s = 32'h1234_5678;
      for (int n = 0; n < 160; n++) begin
        logic [W-1:0] a, b, ta, tb;
        s = s * 32'd1664525 + 32'd1013904223;
        a  = s[31:24]; b = s[23:16];
        ta = s[15:8] & s[7:0] & {W{s[3]}};
        tb = s[14:7] & s[6:0] & {W{s[4]}};
        drive(4'(n % 12), a, ta, b, tb, "R1 R2 R3 R4 R5 R6 R7 R8 R9 sweep");
      end
    end
    repeat (3) @(posedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule